// File: doc/BRIEF.md
# Page Recovery Directory Fill Engine

This engine sits at the home memory controller and consumes one recovery response at a time. A response names a page, the node that keeps that page, and a 64-bit presence vector. Bit i of the vector says that block i of the page is cached at the keeper. For every set bit the engine installs an entry in a set-associative directory cache. The block address of that entry is the page number with the 6-bit block index appended. Each entry records the keeper as the only sharer and is marked exclusive-owned. When the vector has been fully consumed, a target-done message goes back toward the keeper.

The response input is a valid/ready stream. A response is taken on a clock edge where `rsp_valid` and `rsp_ready` are both high. While a response is being worked on, `rsp_ready` stays low, so the sender must hold its data until the engine is free. The target-done output is also valid/ready: `done_valid` stays high and its fields stay stable until `done_ready` is seen high on an edge. While `done_ready` is low, no new response is accepted. Evictions are reported on a plain one-cycle pulse. A combinational lookup port exposes the directory contents to the rest of the controller.

Top module: `dir_fill_engine`

## Requirements
- R1: After reset `rsp_ready` is 1, `done_valid` and `evict_valid` are 0, and every lookup misses (`lk_hit` 0, `lk_state` 2'b00).
- R2: A response is taken only on an edge where `rsp_valid` and `rsp_ready` are both 1. `rsp_ready` is 0 from that edge until the edge on which the target-done message is handed over.
- R3: For each set bit i of the accepted vector, the directory afterwards holds an entry for block address {page, i[5:0]}.
- R4: A newly written entry has a sharer vector with only bit `keeper` set and state 2'b10 (exclusive-owned).
- R5: The vector is walked lowest index first, one entry per clock. With N set bits, `done_valid` becomes 1 after the Nth edge following the accepting edge. An all-zero vector writes nothing and raises `done_valid` right after the accepting edge.
- R6: `done_page` and `done_keeper` equal the page and keeper of the response. While `done_valid` is 1 and `done_ready` is 0, they and `done_valid` hold.
- R7: The set index is the low log2(SETS) bits of the block address. A block with no matching entry takes the lowest-numbered invalid way of its set and raises no eviction.
- R8: If all ways of the set are valid and none matches, a per-set round-robin pointer (starting at way 0 and advancing on each eviction) picks the victim. `evict_valid` pulses for one cycle after that write, with `evict_addr` holding the victim's full block address.
- R9: A block whose address already has an entry is rewritten in that way with the new keeper, and no eviction is raised.
- R10: The lookup outputs follow `lk_addr` combinationally, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Recovery response present |
| rsp_ready | output | 1 | Engine can take a response |
| rsp_page | input | PAGE_W | Page number of the response |
| rsp_keeper | input | log2(NODES) | Node ID of the keeper |
| rsp_vec | input | BLKS | Per-block presence vector |
| done_valid | output | 1 | Target-done message present |
| done_ready | input | 1 | Target-done message taken |
| done_page | output | PAGE_W | Page of the finished response |
| done_keeper | output | log2(NODES) | Destination keeper |
| evict_valid | output | 1 | One-cycle eviction pulse |
| evict_addr | output | PAGE_W+log2(BLKS) | Block address of the evicted entry |
| lk_addr | input | PAGE_W+log2(BLKS) | Lookup block address |
| lk_hit | output | 1 | Lookup address has an entry |
| lk_sharers | output | NODES | Sharer vector of the hit entry |
| lk_state | output | 2 | Entry state, 2'b00 on a miss |

## Verification
The target-done result is due N clock edges after the accepting edge, where N is the number of set bits, or right after the accepting edge when N is 0. The bench counts falling edges from acceptance until `done_valid` shows and compares that count with the popcount it computed. An eviction pulse is due on the cycle after the write that caused it. A monitor sampling on every falling edge pops the expected victim address from a queue at each pulse and fails on any pulse it did not expect. Directory contents are read through the lookup port one time unit after `lk_addr` changes, so nothing depends on a clock edge.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WALK = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_t;

  localparam logic [1:0] DIR_INVALID = 2'b00;
  localparam logic [1:0] DIR_EXCL    = 2'b10;
endpackage

// File: rtl/dfe_bitscan.sv
module dfe_bitscan #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the last hit is the smallest
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[IW-1:0];
    end
  end
  assign any = |vec;
endmodule

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int NODE_W = 3,
  parameter int BLKS   = 64,
  localparam int IDX_W = $clog2(BLKS),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [PAGE_W-1:0] rsp_page,
  input  logic [NODE_W-1:0] rsp_keeper,
  input  logic [BLKS-1:0]   rsp_vec,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [PAGE_W-1:0] done_page,
  output logic [NODE_W-1:0] done_keeper,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NODE_W-1:0] wr_keeper
);
  eng_state_t        state_q;
  logic [BLKS-1:0]   work_q;
  logic [BLKS-1:0]   work_nx;
  logic [PAGE_W-1:0] page_q;
  logic [NODE_W-1:0] keeper_q;
  logic              pend_any;
  logic [IDX_W-1:0]  pend_idx;

  dfe_bitscan #(.W(BLKS), .IW(IDX_W)) u_scan (
    .vec (work_q),
    .any (pend_any),
    .idx (pend_idx)
  );

  assign work_nx   = work_q & ~(BLKS'(1) << pend_idx);
  assign wr_en     = (state_q == ENG_WALK) && pend_any;
  assign wr_addr   = {page_q, pend_idx};
  assign wr_keeper = keeper_q;

  assign rsp_ready   = (state_q == ENG_IDLE);
  assign done_valid  = (state_q == ENG_DONE);
  assign done_page   = page_q;
  assign done_keeper = keeper_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      work_q   <= '0;
      page_q   <= '0;
      keeper_q <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (rsp_valid) begin
            page_q   <= rsp_page;
            keeper_q <= rsp_keeper;
            work_q   <= rsp_vec;
            state_q  <= (rsp_vec == '0) ? ENG_DONE : ENG_WALK;
          end
        end
        ENG_WALK: begin
          work_q <= work_nx;
          if (work_nx == '0) state_q <= ENG_DONE;
        end
        ENG_DONE: begin
          if (done_ready) state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfe_way_pick.sv
module dfe_way_pick #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] hit,
  input  logic [WAYS-1:0] valid,
  input  logic [WW-1:0]   rr,
  output logic [WW-1:0]   way,
  output logic            evict
);
  logic [WW-1:0] hit_way;
  logic [WW-1:0] free_way;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w])    hit_way  = w[WW-1:0];
      if (!valid[w]) free_way = w[WW-1:0];
    end
    if (|hit) begin
      way   = hit_way;
      evict = 1'b0;
    end else if (!(&valid)) begin
      way   = free_way;
      evict = 1'b0;
    end else begin
      way   = rr;
      evict = 1'b1;
    end
  end
endmodule

// File: rtl/dfe_dir_array.sv
module dfe_dir_array
  import dfe_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int NODES  = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int WW     = $clog2(WAYS),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NODE_W-1:0] wr_keeper,
  output logic              evict_valid,
  output logic [ADDR_W-1:0] evict_addr,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [NODES-1:0]  lk_sharers,
  output logic [1:0]        lk_state
);
  logic [WAYS-1:0]  v_q   [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [NODES-1:0] sh_q  [SETS][WAYS];
  logic [1:0]       st_q  [SETS][WAYS];
  logic [WW-1:0]    rr_q  [SETS];

  logic [SET_W-1:0] wr_set;
  logic [TAG_W-1:0] wr_tag;
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  wr_hitv;
  logic [WAYS-1:0]  lk_hitv;
  logic [WW-1:0]    sel_way;
  logic             sel_evict;

  assign wr_set = wr_addr[SET_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:SET_W];
  assign lk_set = lk_addr[SET_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wr_hitv[w] = v_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag);
    assign lk_hitv[w] = v_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  dfe_way_pick #(.WAYS(WAYS)) u_pick (
    .hit   (wr_hitv),
    .valid (v_q[wr_set]),
    .rr    (rr_q[wr_set]),
    .way   (sel_way),
    .evict (sel_evict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s]  <= '0;
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          sh_q[s][w]  <= '0;
          st_q[s][w]  <= DIR_INVALID;
        end
      end
      evict_valid <= 1'b0;
      evict_addr  <= '0;
    end else begin
      evict_valid <= wr_en && sel_evict;
      if (wr_en) begin
        v_q[wr_set][sel_way]   <= 1'b1;
        tag_q[wr_set][sel_way] <= wr_tag;
        sh_q[wr_set][sel_way]  <= NODES'(1) << wr_keeper;
        st_q[wr_set][sel_way]  <= DIR_EXCL;
        if (sel_evict) begin
          rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
          evict_addr   <= {tag_q[wr_set][sel_way], wr_set};
        end
      end
    end
  end

  always_comb begin
    lk_hit     = |lk_hitv;
    lk_sharers = '0;
    lk_state   = DIR_INVALID;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hitv[w]) begin
        lk_sharers = sh_q[lk_set][w];
        lk_state   = st_q[lk_set][w];
      end
    end
  end
endmodule

// File: rtl/dir_fill_engine.sv
module dir_fill_engine #(
  parameter int PAGE_W = 20,
  parameter int NODES  = 8,
  parameter int BLKS   = 64,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W  = $clog2(BLKS),
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [PAGE_W-1:0] rsp_page,
  input  logic [NODE_W-1:0] rsp_keeper,
  input  logic [BLKS-1:0]   rsp_vec,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [PAGE_W-1:0] done_page,
  output logic [NODE_W-1:0] done_keeper,
  output logic              evict_valid,
  output logic [ADDR_W-1:0] evict_addr,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [NODES-1:0]  lk_sharers,
  output logic [1:0]        lk_state
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [NODE_W-1:0] wr_keeper;

  dfe_ctrl #(.PAGE_W(PAGE_W), .NODE_W(NODE_W), .BLKS(BLKS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_page    (rsp_page),
    .rsp_keeper  (rsp_keeper),
    .rsp_vec     (rsp_vec),
    .done_valid  (done_valid),
    .done_ready  (done_ready),
    .done_page   (done_page),
    .done_keeper (done_keeper),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_keeper   (wr_keeper)
  );

  dfe_dir_array #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .NODES(NODES)) u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_keeper   (wr_keeper),
    .evict_valid (evict_valid),
    .evict_addr  (evict_addr),
    .lk_addr     (lk_addr),
    .lk_hit      (lk_hit),
    .lk_sharers  (lk_sharers),
    .lk_state    (lk_state)
  );
endmodule

// File: rtl/dfe_chk.sv
module dfe_chk #(
  parameter int PAGE_W = 20,
  parameter int NODES  = 8,
  parameter int BLKS   = 64,
  localparam int NODE_W = $clog2(NODES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BLKS-1:0]   rsp_vec,
  input logic              done_valid,
  input logic              done_ready,
  input logic [PAGE_W-1:0] done_page,
  input logic [NODE_W-1:0] done_keeper,
  input logic              evict_valid,
  input logic              lk_hit,
  input logic [NODES-1:0]  lk_sharers
);
  AST_BUSY_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !rsp_ready); // R2
  AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_ready); // R2
  AST_ZERO_VEC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_vec == '0) |=> done_valid); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> (done_valid && $stable(done_page) && $stable(done_keeper))); // R6
  AST_EVICT_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !rsp_ready); // R8
  AST_SINGLE_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(lk_sharers) == 1)); // R4
endmodule

bind dir_fill_engine dfe_chk #(.PAGE_W(PAGE_W), .NODES(NODES), .BLKS(BLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_vec     (rsp_vec),
  .done_valid  (done_valid),
  .done_ready  (done_ready),
  .done_page   (done_page),
  .done_keeper (done_keeper),
  .evict_valid (evict_valid),
  .lk_hit      (lk_hit),
  .lk_sharers  (lk_sharers)
);

// File: tb/dir_fill_engine_test.sv
`timescale 1ns/1ps
module dir_fill_engine_test;
  localparam int PAGE_W = 20;
  localparam int NODES  = 8;
  localparam int NODE_W = 3;
  localparam int ADDR_W = 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rsp_valid = 1'b0;
  logic              rsp_ready;
  logic [PAGE_W-1:0] rsp_page = '0;
  logic [NODE_W-1:0] rsp_keeper = '0;
  logic [63:0]       rsp_vec = '0;
  logic              done_valid;
  logic              done_ready = 1'b1;
  logic [PAGE_W-1:0] done_page;
  logic [NODE_W-1:0] done_keeper;
  logic              evict_valid;
  logic [ADDR_W-1:0] evict_addr;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              lk_hit;
  logic [NODES-1:0]  lk_sharers;
  logic [1:0]        lk_state;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [NODE_W-1:0] keeper;
  } done_item_t;
  done_item_t        done_q[$];
  logic [ADDR_W-1:0] ev_q[$];

  always #10 clk = ~clk;

  dir_fill_engine uut (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_page(rsp_page),
    .rsp_keeper(rsp_keeper), .rsp_vec(rsp_vec),
    .done_valid(done_valid), .done_ready(done_ready), .done_page(done_page),
    .done_keeper(done_keeper),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_sharers(lk_sharers), .lk_state(lk_state)
  );

  function automatic logic [ADDR_W-1:0] blk(input logic [PAGE_W-1:0] p, input int i);
    return {p, i[5:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: pops expected done messages and victims as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_valid && done_ready) begin
        if (done_q.size() == 0) check(1'b0, "R6", "unexpected done", 64'(done_page), 64'hx);
        else begin
          done_item_t d;
          d = done_q.pop_front();
          check(done_page == d.page && done_keeper == d.keeper, "R6", "done page/keeper",
                {done_page, done_keeper}, {d.page, d.keeper});
        end
      end
      if (evict_valid) begin
        if (ev_q.size() == 0) check(1'b0, "R8", "unexpected eviction", 64'(evict_addr), 64'hx);
        else begin
          logic [ADDR_W-1:0] e;
          e = ev_q.pop_front();
          check(evict_addr == e, "R8", "victim address", 64'(evict_addr), 64'(e));
        end
      end
    end
  end

  // driver: queue expectations, send one response, time done_valid
  task automatic send(input logic [PAGE_W-1:0] p, input logic [NODE_W-1:0] k,
                      input logic [63:0] v, input bit stall);
    int k_cnt;
    int exp_n;
    done_item_t d;
    exp_n = $countones(v);
    d.page = p; d.keeper = k;
    done_q.push_back(d);
    @(negedge clk);
    check(rsp_ready == 1'b1, "R2", "ready before send", 64'(rsp_ready), 64'd1);
    if (stall) done_ready = 1'b0;
    rsp_valid = 1'b1; rsp_page = p; rsp_keeper = k; rsp_vec = v;
    @(negedge clk);
    rsp_valid = 1'b0;
    k_cnt = 0;
    while (!done_valid && k_cnt < 200) begin
      check(rsp_ready == 1'b0, "R2", "ready low while walking", 64'(rsp_ready), 64'd0);
      @(negedge clk);
      k_cnt++;
    end
    check(k_cnt == exp_n, "R5", "cycles to done", 64'(k_cnt), 64'(exp_n));
    if (stall) begin
      repeat (3) begin
        @(negedge clk);
        check(done_valid && !rsp_ready && done_page == p && done_keeper == k, "R6",
              "done held under back-pressure", {done_valid, rsp_ready}, 64'b10);
      end
      done_ready = 1'b1;
    end
    @(negedge clk);
    check(rsp_ready == 1'b1, "R2", "ready after handover", 64'(rsp_ready), 64'd1);
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input bit hit, input int keeper,
                      input string req);
    logic [NODES-1:0] sh;
    logic [1:0]       st;
    sh = hit ? (NODES'(1) << keeper) : '0;
    st = hit ? 2'b10 : 2'b00;
    lk_addr = a;
    #1;
    check(lk_hit == hit && lk_sharers == sh && lk_state == st, req, "lookup",
          {lk_hit, lk_sharers, lk_state}, {hit, sh, st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
    report();
  end

  initial begin
    logic [PAGE_W-1:0] pa, pz, pp, pq, pr, pf;
    pa = 20'h111; pz = 20'h222; pp = 20'h333; pq = 20'h444; pr = 20'h555; pf = 20'h666;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_ready && !done_valid && !evict_valid, "R1", "reset outputs",
          {rsp_ready, done_valid, evict_valid}, 64'b100);
    look(blk(pa, 0), 0, 0, "R1");

    // R3 R4 R7: fill set 0 ways 0..3 and set 5 way 0, no evictions
    send(pa, 3'd2, (64'd1 << 0) | (64'd1 << 16) | (64'd1 << 32) | (64'd1 << 48) | (64'd1 << 5), 0);
    look(blk(pa, 0), 1, 2, "R3");
    look(blk(pa, 48), 1, 2, "R4");
    look(blk(pa, 5), 1, 2, "R7");
    look(blk(pa, 1), 0, 0, "R3");
    look(blk(pa, 5), 1, 2, "R10");

    // R5: zero vector, done right after acceptance, with back-pressure (R6)
    send(pz, 3'd3, 64'd0, 1);

    // R9: rewrite existing entry in place, no eviction
    send(pa, 3'd5, 64'd1 << 16, 0);
    look(blk(pa, 16), 1, 5, "R9");

    // R8: round-robin victims in a full set
    ev_q.push_back(blk(pa, 0));
    ev_q.push_back(blk(pa, 16));
    send(pp, 3'd1, (64'd1 << 0) | (64'd1 << 16), 0);
    look(blk(pa, 0), 0, 0, "R8");
    ev_q.push_back(blk(pa, 32));
    ev_q.push_back(blk(pa, 48));
    send(pq, 3'd4, (64'd1 << 32) | (64'd1 << 48), 0);
    // R5: lowest index first means way 0 holds pp:0, not pp:16
    ev_q.push_back(blk(pp, 0));
    send(pr, 3'd6, 64'd1 << 0, 0);
    look(blk(pp, 0), 0, 0, "R5");
    look(blk(pp, 16), 1, 1, "R5");

    // full vector: 64 allocations, evictions in set 0 and set 5
    ev_q.push_back(blk(pp, 16));
    ev_q.push_back(blk(pq, 32));
    ev_q.push_back(blk(pq, 48));
    ev_q.push_back(blk(pr, 0));
    ev_q.push_back(blk(pa, 5));
    send(pf, 3'd7, '1, 0);
    look(blk(pf, 63), 1, 7, "R3");
    look(blk(pf, 0), 1, 7, "R4");
    look(blk(pa, 5), 0, 0, "R8");

    repeat (2) @(negedge clk);
    check(ev_q.size() == 0, "R8", "pending victims", 64'(ev_q.size()), 64'd0);
    check(done_q.size() == 0, "R6", "pending done messages", 64'(done_q.size()), 64'd0);
    report();
  end
endmodule